// File: doc/BRIEF.md
# Row-Cached DRAM Access Controller

This block sits in front of a DRAM array and keeps one full row of it in a row-wide cache register. A tag register holds the address of the row that the cache holds. A host opens a row cycle by raising a row strobe together with a row address and two selects, one for read or write and one for refresh. The controller compares the row against the tag and puts the cycle into one of five classes. Column requests then read or write individual words of that page. The cycle stays open until the row strobe drops.

Only a read miss changes the tag. It copies the whole addressed row from the array into the cache in a single busy cycle. Writes to the cached row update the array and the cache together. Writes to any other row update the array alone, and cache reads are blocked while such a cycle is open. A refresh cycle leaves the cache and the tag alone. Between row cycles the cache keeps serving column reads, so the host may drop the row strobe straight after a miss and go on reading the page.

Top module: `row_cached_dram_ctl`

## Requirements
- R1: After reset, busy, rd_valid and cache_rd_en are 0 and cyc_class is 0 (idle). The tag is invalid, so an idle column read gives no rd_valid and the first read cycle of any row is a miss.
- R2: A read cycle whose row equals the valid tag is class 1. It raises no busy, and each column read returns the cached word one cycle after the request.
- R3: A read cycle whose row differs from the tag, or finds the tag invalid, is class 2. busy is high for exactly the one cycle after the opening edge. The whole row is loaded into the cache, the tag takes the row, and later column reads return that row's array contents.
- R4: A column read presented while busy is high is held. It is answered with rd_valid and the fetched word in the cycle in which busy has just fallen.
- R5: A write cycle whose row equals the valid tag is class 3. A column request with col_we=1 writes wr_data into both the array and the cache, and later hits and later refetches both return the new word.
- R6: During a class 3 cycle cache_rd_en stays 1, and a column request with col_we=0 returns the cached word.
- R7: A write cycle whose row differs from the tag, or finds the tag invalid, is class 4. Column writes reach only the array, and the tag and cache are unchanged. cache_rd_en is 0 for the whole cycle, and column requests with col_we=0 produce no rd_valid.
- R8: Within one open row cycle any number of column requests, in any column order, are each served without reopening the row.
- R9: When row_refresh is set at the opening edge, the cycle is class 5, whatever row_wr is. It leaves the tag and cache unchanged, keeps cache_rd_en at 1, and serves column reads from the cache. The next read of the tagged row is still a hit.
- R10: When row_open is low at a clock edge the open cycle closes, and cyc_class returns to 0 one cycle later. While idle with a valid tag, column reads are served from the cache with busy low.
- R11: A column request in the same cycle as a row opening is ignored: no rd_valid follows it.
- R12: rd_valid is high only in the cycle after an accepted column read. rd_data holds its value until the next read is answered.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| row_open | input | 1 | Row strobe; high opens a cycle from idle, low closes it |
| row_wr | input | 1 | 1 = write cycle, 0 = read cycle, sampled at opening |
| row_refresh | input | 1 | 1 = refresh cycle, sampled at opening, takes priority |
| row_addr | input | ROW_W | Row address sampled at opening |
| col_req | input | 1 | Column request strobe, one per clock |
| col_we | input | 1 | 1 = column write (only in write cycles) |
| col_addr | input | COL_W | Column address |
| wr_data | input | DATA_W | Column write data |
| busy | output | 1 | High while a row fetch is in progress |
| cache_rd_en | output | 1 | Cache reads are currently allowed |
| cyc_class | output | 3 | 0 idle, 1 read hit, 2 read miss, 3 write hit, 4 write miss, 5 refresh |
| rd_valid | output | 1 | rd_data carries a new read result |
| rd_data | output | DATA_W | Read data |

## Verification
The bench fills every location of a small array with write-miss cycles and then sweeps every row as a miss followed by a hit. A design that loaded the tag on writes would report hits on rows that were never fetched and return stale words. A write hit that skipped the array would show up when the row is evicted and fetched again. A write miss that touched the cache would corrupt later hits on the tagged row. The bench also places a column read inside the busy cycle and another on the opening edge. A controller that dropped the held read, or answered the opening-edge request from the old cache, fails the rd_valid checks there.

// File: rtl/rcd_pkg.sv
package rcd_pkg;

   typedef enum logic [2:0] {
      CLS_IDLE    = 3'd0,
      CLS_RD_HIT  = 3'd1,
      CLS_RD_MISS = 3'd2,
      CLS_WR_HIT  = 3'd3,
      CLS_WR_MISS = 3'd4,
      CLS_REFRESH = 3'd5
   } cyc_class_e;

   typedef enum logic [1:0] {
      ST_IDLE   = 2'd0,
      ST_FETCH  = 2'd1,
      ST_ACTIVE = 2'd2
   } ctl_state_e;

   // refresh wins over the read/write select
   function automatic cyc_class_e classify(input logic refresh,
                                           input logic wr,
                                           input logic hit);
      cyc_class_e c;
      if (refresh)      c = CLS_REFRESH;
      else if (!wr)     c = hit ? CLS_RD_HIT : CLS_RD_MISS;
      else              c = hit ? CLS_WR_HIT : CLS_WR_MISS;
      return c;
   endfunction

endpackage

// File: rtl/rcd_tag_latch.sv
module rcd_tag_latch #(
   parameter int ROW_W = 11
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load,
   input  logic [ROW_W-1:0] load_row,
   input  logic [ROW_W-1:0] probe_row,
   output logic [ROW_W-1:0] tag,
   output logic             tag_valid,
   output logic             match
);

   logic [ROW_W-1:0] tag_q;
   logic             valid_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         tag_q   <= '0;
         valid_q <= 1'b0;
      end else if (load) begin
         tag_q   <= load_row;
         valid_q <= 1'b1;
      end
   end

   assign tag       = tag_q;
   assign tag_valid = valid_q;
   assign match     = valid_q && (probe_row == tag_q);

   // once a row has been fetched the tag never becomes invalid again
   p_valid_sticky_r1: assert property (@(posedge clk) disable iff (!rst_n)
      tag_valid |=> tag_valid);

endmodule

// File: rtl/rcd_row_cache.sv
module rcd_row_cache #(
   parameter int COL_W      = 4,
   parameter int DATA_W     = 8,
   parameter bit ONEHOT_MUX = 1'b0
) (
   input  logic                               clk,
   input  logic                               rst_n,
   input  logic                               fill_en,
   input  logic [(1<<COL_W)-1:0][DATA_W-1:0]  fill_line,
   input  logic                               wr_en,
   input  logic [COL_W-1:0]                   wr_col,
   input  logic [DATA_W-1:0]                  wr_data,
   input  logic [COL_W-1:0]                   rd_col,
   output logic [DATA_W-1:0]                  rd_word
);

   localparam int COLS = 1 << COL_W;

   logic [DATA_W-1:0] word_bus [COLS];

   for (genvar c = 0; c < COLS; c++) begin : g_word
      logic [DATA_W-1:0] w_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)                                  w_q <= '0;
         else if (fill_en)                            w_q <= fill_line[c];
         else if (wr_en && (wr_col == COL_W'(c)))     w_q <= wr_data;
      end
      assign word_bus[c] = w_q;
   end

   if (ONEHOT_MUX) begin : g_mux_onehot
      logic [COLS-1:0] sel;
      always_comb begin
         rd_word = '0;
         for (int c = 0; c < COLS; c++) begin
            sel[c]  = (rd_col == COL_W'(c));
            rd_word = rd_word | (word_bus[c] & {DATA_W{sel[c]}});
         end
      end
   end else begin : g_mux_index
      assign rd_word = word_bus[rd_col];
   end

   // a fetch and a column write never share a cycle
   p_fill_wr_excl_r3: assert property (@(posedge clk) disable iff (!rst_n)
      fill_en |-> !wr_en);

endmodule

// File: rtl/rcd_dram_array.sv
module rcd_dram_array #(
   parameter int ROW_W  = 11,
   parameter int COL_W  = 4,
   parameter int DATA_W = 8
) (
   input  logic                               clk,
   input  logic                               wr_en,
   input  logic [ROW_W-1:0]                   wr_row,
   input  logic [COL_W-1:0]                   wr_col,
   input  logic [DATA_W-1:0]                  wr_data,
   input  logic [ROW_W-1:0]                   rd_row,
   output logic [(1<<COL_W)-1:0][DATA_W-1:0]  rd_line
);

   localparam int ROWS = 1 << ROW_W;
   localparam int COLS = 1 << COL_W;

   if (ROW_W > 12) begin : g_bad_depth
      $error("rcd_dram_array: ROW_W too large for a behavioural array");
   end

   logic [COLS-1:0][DATA_W-1:0] mem [ROWS];

   always_ff @(posedge clk) begin
      if (wr_en) mem[wr_row][wr_col] <= wr_data;
   end

   assign rd_line = mem[rd_row];

endmodule

// File: rtl/row_cached_dram_ctl.sv
module row_cached_dram_ctl
   import rcd_pkg::*;
#(
   parameter int ROW_W      = 11,
   parameter int COL_W      = 4,
   parameter int DATA_W     = 8,
   parameter bit ONEHOT_MUX = 1'b0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              row_open,
   input  logic              row_wr,
   input  logic              row_refresh,
   input  logic [ROW_W-1:0]  row_addr,
   input  logic              col_req,
   input  logic              col_we,
   input  logic [COL_W-1:0]  col_addr,
   input  logic [DATA_W-1:0] wr_data,
   output logic              busy,
   output logic              cache_rd_en,
   output logic [2:0]        cyc_class,
   output logic              rd_valid,
   output logic [DATA_W-1:0] rd_data
);

   localparam int COLS = 1 << COL_W;

   if (ROW_W < 1 || COL_W < 1 || DATA_W < 1) begin : g_bad_width
      $error("row_cached_dram_ctl: widths must be positive");
   end
   if (COL_W > 8) begin : g_bad_cols
      $error("row_cached_dram_ctl: COL_W makes the cache row too wide");
   end

   ctl_state_e              state_q, state_d;
   cyc_class_e              cls_q, cls_d;
   logic [ROW_W-1:0]        row_q;
   logic                    open_now;
   logic                    tag_match, tag_valid;
   logic [ROW_W-1:0]        tag_w;
   logic                    fetching;
   logic                    col_go, is_wr_cyc, do_write, do_read, fetch_serve;
   logic                    wr_miss_open;
   logic [COLS-1:0][DATA_W-1:0] line_w;
   logic [DATA_W-1:0]       cache_word;
   logic                    rd_valid_q;
   logic [DATA_W-1:0]       rd_data_q;

   // ---------------- cycle control ----------------
   assign open_now = (state_q == ST_IDLE) && row_open;
   assign fetching = (state_q == ST_FETCH);

   always_comb begin
      state_d = state_q;
      cls_d   = cls_q;
      unique case (state_q)
         ST_IDLE: begin
            if (row_open) begin
               cls_d   = classify(row_refresh, row_wr, tag_match);
               state_d = (cls_d == CLS_RD_MISS) ? ST_FETCH : ST_ACTIVE;
            end
         end
         ST_FETCH: state_d = ST_ACTIVE;
         ST_ACTIVE: begin
            if (!row_open) begin
               state_d = ST_IDLE;
               cls_d   = CLS_IDLE;
            end
         end
         default: begin
            state_d = ST_IDLE;
            cls_d   = CLS_IDLE;
         end
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= ST_IDLE;
         cls_q   <= CLS_IDLE;
         row_q   <= '0;
      end else begin
         state_q <= state_d;
         cls_q   <= cls_d;
         if (open_now) row_q <= row_addr;
      end
   end

   // ---------------- column decode ----------------
   assign wr_miss_open = (state_q == ST_ACTIVE) && (cls_q == CLS_WR_MISS);
   assign is_wr_cyc    = (state_q == ST_ACTIVE) &&
                         ((cls_q == CLS_WR_HIT) || (cls_q == CLS_WR_MISS));
   assign cache_rd_en  = tag_valid && !fetching && !wr_miss_open;
   assign col_go       = col_req && !open_now && !fetching;
   assign do_write     = col_go && is_wr_cyc && col_we;
   assign do_read      = col_go && !do_write && cache_rd_en;
   assign fetch_serve  = fetching && col_req;

   // ---------------- storage ----------------
   rcd_tag_latch #(.ROW_W(ROW_W)) u_tag (
      .clk       (clk),
      .rst_n     (rst_n),
      .load      (fetching),
      .load_row  (row_q),
      .probe_row (row_addr),
      .tag       (tag_w),
      .tag_valid (tag_valid),
      .match     (tag_match)
   );

   rcd_dram_array #(.ROW_W(ROW_W), .COL_W(COL_W), .DATA_W(DATA_W)) u_array (
      .clk     (clk),
      .wr_en   (do_write),
      .wr_row  (row_q),
      .wr_col  (col_addr),
      .wr_data (wr_data),
      .rd_row  (row_q),
      .rd_line (line_w)
   );

   rcd_row_cache #(.COL_W(COL_W), .DATA_W(DATA_W), .ONEHOT_MUX(ONEHOT_MUX)) u_cache (
      .clk       (clk),
      .rst_n     (rst_n),
      .fill_en   (fetching),
      .fill_line (line_w),
      .wr_en     (do_write && (cls_q == CLS_WR_HIT)),
      .wr_col    (col_addr),
      .wr_data   (wr_data),
      .rd_col    (col_addr),
      .rd_word   (cache_word)
   );

   // ---------------- read return ----------------
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rd_valid_q <= 1'b0;
         rd_data_q  <= '0;
      end else begin
         rd_valid_q <= fetch_serve || do_read;
         if (fetch_serve)  rd_data_q <= line_w[col_addr];
         else if (do_read) rd_data_q <= cache_word;
      end
   end

   assign busy      = fetching;
   assign cyc_class = cls_q;
   assign rd_valid  = rd_valid_q;
   assign rd_data   = rd_data_q;

   // ---------------- assertions ----------------
   p_busy_single_r3: assert property (@(posedge clk) disable iff (!rst_n)
      busy |=> !busy);

   p_busy_miss_only_r3: assert property (@(posedge clk) disable iff (!rst_n)
      busy |-> (cyc_class == CLS_RD_MISS));

   p_miss_loads_tag_r3: assert property (@(posedge clk) disable iff (!rst_n)
      busy |=> (tag_valid && (tag_w == $past(row_q))));

   p_hit_no_busy_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (cyc_class == CLS_RD_HIT) |-> !busy);

   p_wrmiss_blocks_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (cyc_class == CLS_WR_MISS) |-> !cache_rd_en);

   // R7 and R9: write-miss and refresh cycles keep the tag
   p_tag_kept_r7: assert property (@(posedge clk) disable iff (!rst_n)
      ((cyc_class == CLS_WR_MISS) || (cyc_class == CLS_REFRESH)) |=> $stable(tag_w));

   p_open_ignores_col_r11: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == ST_IDLE && row_open && col_req) |=> !rd_valid);

   p_rdv_cause_r12: assert property (@(posedge clk) disable iff (!rst_n)
      rd_valid |-> $past(col_req));

endmodule

// File: tb/tb_row_cached_dram_ctl.sv
`timescale 1ns/1ps
module tb_row_cached_dram_ctl;

   localparam int ROW_W  = 4;
   localparam int COL_W  = 3;
   localparam int DATA_W = 8;
   localparam int ROWS   = 1 << ROW_W;
   localparam int COLS   = 1 << COL_W;

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic              row_open = 0, row_wr = 0, row_refresh = 0;
   logic [ROW_W-1:0]  row_addr = '0;
   logic              col_req = 0, col_we = 0;
   logic [COL_W-1:0]  col_addr = '0;
   logic [DATA_W-1:0] wr_data = '0;
   logic              busy, cache_rd_en, rd_valid;
   logic [2:0]        cyc_class;
   logic [DATA_W-1:0] rd_data;

   always #2 clk = ~clk;

   row_cached_dram_ctl #(.ROW_W(ROW_W), .COL_W(COL_W), .DATA_W(DATA_W)) dut (
      .clk(clk), .rst_n(rst_n), .row_open(row_open), .row_wr(row_wr),
      .row_refresh(row_refresh), .row_addr(row_addr), .col_req(col_req),
      .col_we(col_we), .col_addr(col_addr), .wr_data(wr_data), .busy(busy),
      .cache_rd_en(cache_rd_en), .cyc_class(cyc_class), .rd_valid(rd_valid),
      .rd_data(rd_data)
   );

   int checks = 0;
   int failures = 0;

   logic [DATA_W-1:0] ref_mem [ROWS][COLS];
   logic [DATA_W-1:0] ref_cache [COLS];
   logic [ROW_W-1:0]  ref_tag = '0;
   logic [ROW_W-1:0]  ref_row = '0;
   logic              ref_tv = 1'b0;
   int                ref_cls = 0;

   function automatic logic [DATA_W-1:0] pat(int r, int c, int p);
      return DATA_W'(r * 37 + c * 11 + p * 73 + 5);
   endfunction

   task automatic check(string req, string what, logic [31:0] act, logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         failures++;
         $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
      end
   endtask

   function automatic int model_open(logic wr, logic refr, logic [ROW_W-1:0] row);
      logic hit;
      int   cls;
      hit = ref_tv && (ref_tag == row);
      if (refr)     cls = 5;
      else if (!wr) cls = hit ? 1 : 2;
      else          cls = hit ? 3 : 4;
      if (cls == 2) begin
         for (int c = 0; c < COLS; c++) ref_cache[c] = ref_mem[row][c];
         ref_tag = row;
         ref_tv  = 1'b1;
      end
      if (!refr) ref_row = row;
      ref_cls = cls;
      return cls;
   endfunction

   task automatic open_row(logic wr, logic refr, logic [ROW_W-1:0] row, string req);
      int cls;
      @(negedge clk);
      row_open = 1; row_wr = wr; row_refresh = refr; row_addr = row; col_req = 0;
      cls = model_open(wr, refr, row);
      @(negedge clk);
      check(req, "class", 32'(cyc_class), 32'(cls));
      check(req, "busy", 32'(busy), 32'(cls == 2));
      check(req, "cache_rd_en", 32'(cache_rd_en),
            32'((cls != 2) && ref_tv && (cls != 4)));
      row_refresh = 0;
   endtask

   task automatic col_op(logic we, int col, logic [DATA_W-1:0] d, string req);
      logic exp_v;
      logic [DATA_W-1:0] exp_d;
      @(negedge clk);
      col_req = 1; col_we = we; col_addr = COL_W'(col); wr_data = d;
      exp_d = '0;
      if (we && (ref_cls == 3 || ref_cls == 4)) begin
         ref_mem[ref_row][col] = d;
         if (ref_cls == 3) ref_cache[col] = d;
         exp_v = 1'b0;
      end else begin
         exp_v = ref_tv && (ref_cls != 4);
         exp_d = ref_cache[col];
      end
      @(negedge clk);
      col_req = 0; col_we = 0;
      check(req, "rd_valid", 32'(rd_valid), 32'(exp_v));
      if (exp_v) check(req, "rd_data", 32'(rd_data), 32'(exp_d));
   endtask

   task automatic close_row(string req);
      @(negedge clk);
      row_open = 0;
      ref_cls = 0;
      @(negedge clk);
      check(req, "class idle", 32'(cyc_class), 32'd0);
      check(req, "busy idle", 32'(busy), 32'd0);
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      failures++;
      $display("FAIL watchdog: run did not finish actual=hung expected=done");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin
      logic [ROW_W-1:0] t;
      logic [DATA_W-1:0] held;
      repeat (3) @(negedge clk);
      check("R1", "busy", 32'(busy), 0);
      check("R1", "rd_valid", 32'(rd_valid), 0);
      check("R1", "class", 32'(cyc_class), 0);
      rst_n = 1;
      @(negedge clk);
      check("R1", "cache_rd_en", 32'(cache_rd_en), 0);
      col_op(1'b0, 3, '0, "R1");

      // fill every row through write cycles (tag invalid: all write misses)
      for (int r = 0; r < ROWS; r++) begin
         open_row(1'b1, 1'b0, ROW_W'(r), "R7");
         for (int c = 0; c < COLS; c++) col_op(1'b1, c, pat(r, c, 0), "R7");
         if (r == 0) col_op(1'b0, 1, '0, "R7");
         close_row("R10");
      end

      // sweep: miss, early release, then hit in reverse column order
      for (int r = 0; r < ROWS; r++) begin
         open_row(1'b0, 1'b0, ROW_W'(r), "R3");
         for (int c = 0; c < COLS; c++) col_op(1'b0, c, '0, "R8");
         close_row("R10");
         col_op(1'b0, (r + 3) % COLS, '0, "R10");
         open_row(1'b0, 1'b0, ROW_W'(r), "R2");
         for (int c = COLS - 1; c >= 0; c--) col_op(1'b0, c, '0, "R2");
         close_row("R2");
      end

      // refresh keeps the cached row
      row_wr = 1;
      open_row(1'b1, 1'b1, ROW_W'(5), "R9");
      col_op(1'b0, 2, '0, "R9");
      close_row("R9");
      open_row(1'b0, 1'b0, ref_tag, "R9");
      close_row("R9");

      // write hit: array and cache both updated
      t = ref_tag;
      open_row(1'b1, 1'b0, t, "R5");
      for (int c = 0; c < COLS; c++) begin
         col_op(1'b1, c, pat(int'(t), c, 1), "R5");
         col_op(1'b0, c, '0, "R6");
      end
      close_row("R5");
      open_row(1'b0, 1'b0, t, "R5");
      for (int c = 0; c < COLS; c++) col_op(1'b0, c, '0, "R5");
      close_row("R5");
      open_row(1'b0, 1'b0, ROW_W'(3), "R3");
      close_row("R3");
      open_row(1'b0, 1'b0, t, "R5");
      for (int c = 0; c < COLS; c++) col_op(1'b0, c, '0, "R5");
      close_row("R5");

      // write miss: cache and tag untouched
      open_row(1'b1, 1'b0, ROW_W'(9), "R7");
      for (int c = 0; c < COLS; c++) col_op(1'b1, c, pat(9, c, 2), "R7");
      col_op(1'b0, 0, '0, "R7");
      close_row("R7");
      open_row(1'b0, 1'b0, t, "R7");
      for (int c = 0; c < COLS; c++) col_op(1'b0, c, '0, "R7");
      close_row("R7");
      open_row(1'b0, 1'b0, ROW_W'(9), "R7");
      for (int c = 0; c < COLS; c++) col_op(1'b0, c, '0, "R7");
      close_row("R7");

      // column read held across the busy cycle
      @(negedge clk);
      row_open = 1; row_wr = 0; row_addr = ROW_W'(2);
      void'(model_open(1'b0, 1'b0, ROW_W'(2)));
      @(negedge clk);
      check("R4", "busy", 32'(busy), 1);
      col_req = 1; col_we = 0; col_addr = COL_W'(6);
      @(negedge clk);
      col_req = 0;
      check("R4", "busy fell", 32'(busy), 0);
      check("R4", "rd_valid", 32'(rd_valid), 1);
      check("R4", "rd_data", 32'(rd_data), 32'(ref_mem[2][6]));
      col_op(1'b0, 4, '0, "R4");
      close_row("R4");

      // column request on the opening edge is ignored
      @(negedge clk);
      row_open = 1; row_wr = 0; row_addr = ROW_W'(2);
      col_req = 1; col_addr = COL_W'(1);
      void'(model_open(1'b0, 1'b0, ROW_W'(2)));
      @(negedge clk);
      col_req = 0;
      check("R11", "rd_valid", 32'(rd_valid), 0);
      check("R11", "class", 32'(cyc_class), 1);
      col_op(1'b0, 5, '0, "R12");
      held = ref_cache[5];
      @(negedge clk);
      check("R12", "rd_valid drop", 32'(rd_valid), 0);
      check("R12", "rd_data held", 32'(rd_data), 32'(held));
      close_row("R12");

      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

endmodule